// File: doc/BRIEF.md
# PC Sampling Debug Register Slave

This block is the external-debug view of program-counter sampling for one core, reached over a single APB3 slave port. Debug software reads a low PC sample word. That read returns the live low half of the core's program counter. In the same clock edge it freezes the upper PC half, the context identifier and the virtual-machine/exception-state word into snapshot registers. Later reads of those three registers then describe the same instant as the low-half read, even after the core has moved on.

The block also holds an OS lock, a power control register whose bits drive the core power-up and no-powerdown request lines, and a read-only power status register that mirrors the core-power and double-lock inputs. Two identification registers report which sample registers exist and how the PC value should be interpreted. The sample registers are fenced off while the core is unpowered or double-locked. The control, status and identification registers stay reachable in that state, so software can request power and retry.

The bus has no back-pressure. PREADY is tied high and every transfer completes in its first access-phase cycle (PSEL and PENABLE both high). A master may issue back-to-back transfers with no stall. Read data and PSLVERR are valid only in that access cycle, and reads return zero outside it.

Top module: `pcs_dbg_regs`

## Requirements
- R1: After reset the power control bits and both request outputs are 0, every snapshot register reads 0, and the OS lock is set (power status bit 5 reads 1). PREADY is always 1.
- R2: A read of offset 0x0A0 while permitted returns the live PC bits 31:0. In the same edge it captures PC bits 63:32 (read at 0x0AC), the context ID (0x0A4) and the VMID word (0x0A8). Those three reads keep returning the captured values until the next capturing read, whatever the inputs do.
- R3: When the core is halted in debug or profiling is prohibited (and access is not blocked), a read of 0x0A0 returns 0xFFFFFFFF and captures nothing.
- R4: The VMID word places non-secure at bit 31, EL2 at bit 30, EL3 at bit 29, 64-bit state at bit 28 and the VMID in bits 7:0. All other bits are 0.
- R5: A write to 0x300 clears the OS lock when the data is zero and sets it for any non-zero value. While the lock is set, a read of 0x0A0 still returns the live low PC but captures nothing.
- R6: While core power is off or the double lock is set, any access to 0x0A0–0x0AC returns 0 with PSLVERR high and captures nothing.
- R7: Offsets 0x300, 0x310, 0x314, 0xFC4 and 0xFC8 never raise PSLVERR, including while the core is unpowered or double-locked.
- R8: Power status (0x314) is read-only. Bit 0 is core powered, bit 5 is OS lock set, bit 6 is double lock set, and the rest are 0.
- R9: Power control (0x310) stores bit 3, which drives `req_pwrup`, and bit 0, which drives `req_nopd`. Both outputs change on the edge that ends the write. The other bits read 0.
- R10: Device ID (0xFC8) bits 3:0 read the sample mode parameter. Device ID1 (0xFC4) bits 3:0 read the PC offset code parameter. All other bits are 0.
- R11: Unmapped offsets, and offsets with non-zero low address bits, read 0 with no error. Writes to sample, status and ID registers have no effect.
- R12: With sample mode 1 (PC only), the context ID and VMID registers read 0. With mode 2 only the VMID register reads 0. The PC high half is captured in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | AW | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error on blocked sample access |
| core_pc | input | PCW | Live program counter |
| core_ctxid | input | 32 | Live context ID |
| core_vmid | input | VMW | Live VMID |
| core_ns | input | 1 | Core in non-secure state |
| core_el2 | input | 1 | Core at EL2 |
| core_el3 | input | 1 | Core at EL3 |
| core_wide | input | 1 | Core in 64-bit state |
| core_halted | input | 1 | Core in debug state |
| prof_prohibit | input | 1 | Sample profiling prohibited |
| core_pwr_up | input | 1 | Core power domain on |
| core_dlock | input | 1 | OS double lock set |
| req_pwrup | output | 1 | Core power-up request |
| req_nopd | output | 1 | No-powerdown request |

## Verification
The bench targets the snapshot coherency rule. It changes the live PC, context ID and VMID after a capture and confirms that the companion registers still hold the older values. A design that read these registers live, or captured them a cycle late, would return the new values. It then checks each condition that must suppress capture: OS lock set, prohibited or halted, and unpowered or double-locked. A design that let any of them through would show a fresh upper PC half on the next 0x0AC read. It also confirms that the power and lock registers stay error-free while the sample registers fail. A second instance in PC-only mode shows that the absent registers read zero.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam logic [11:0] OFS_PCLO    = 12'h0A0;
  localparam logic [11:0] OFS_CTX     = 12'h0A4;
  localparam logic [11:0] OFS_VMID    = 12'h0A8;
  localparam logic [11:0] OFS_PCHI    = 12'h0AC;
  localparam logic [11:0] OFS_OSLOCK  = 12'h300;
  localparam logic [11:0] OFS_PWRCTL  = 12'h310;
  localparam logic [11:0] OFS_PWRSTAT = 12'h314;
  localparam logic [11:0] OFS_DEVID1  = 12'hFC4;
  localparam logic [11:0] OFS_DEVID   = 12'hFC8;

  localparam int CTL_PWRUP_BIT = 3;
  localparam int CTL_NOPD_BIT  = 0;
  localparam int ST_PWR_BIT    = 0;
  localparam int ST_OSLK_BIT   = 5;
  localparam int ST_DLK_BIT    = 6;

  localparam logic [31:0] SAMPLE_BLOCKED = 32'hFFFF_FFFF;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_PCLO,
    SEL_CTX,
    SEL_VMID,
    SEL_PCHI,
    SEL_OSLOCK,
    SEL_PWRCTL,
    SEL_PWRSTAT,
    SEL_DEVID1,
    SEL_DEVID
  } reg_sel_e;
endpackage

// File: rtl/pcs_addr_dec.sv
module pcs_addr_dec
  import pcs_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0] paddr,
  output reg_sel_e      sel,
  output logic          is_sample
);
  localparam int PAD = AW - 12;

  logic [11:0] low_addr;
  logic        upper_zero;

  generate
    if (PAD > 0) begin : g_wide
      assign upper_zero = ~|paddr[AW-1:12];
    end else begin : g_narrow
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign low_addr = paddr[11:0];

  always_comb begin
    sel = SEL_NONE;
    if (upper_zero) begin
      case (low_addr)
        OFS_PCLO:    sel = SEL_PCLO;
        OFS_CTX:     sel = SEL_CTX;
        OFS_VMID:    sel = SEL_VMID;
        OFS_PCHI:    sel = SEL_PCHI;
        OFS_OSLOCK:  sel = SEL_OSLOCK;
        OFS_PWRCTL:  sel = SEL_PWRCTL;
        OFS_PWRSTAT: sel = SEL_PWRSTAT;
        OFS_DEVID1:  sel = SEL_DEVID1;
        OFS_DEVID:   sel = SEL_DEVID;
        default:     sel = SEL_NONE;
      endcase
    end
  end

  assign is_sample = (sel == SEL_PCLO) || (sel == SEL_CTX) ||
                     (sel == SEL_VMID) || (sel == SEL_PCHI);
endmodule

// File: rtl/pcs_sample_bank.sv
module pcs_sample_bank #(
  parameter int PCW  = 64,
  parameter int VMW  = 8,
  parameter int MODE = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic [PCW-1:0] pc_in,
  input  logic [31:0]    ctx_in,
  input  logic [VMW-1:0] vmid_in,
  input  logic           ns_in,
  input  logic           el2_in,
  input  logic           el3_in,
  input  logic           wide_in,
  output logic [31:0]    snap_hi,
  output logic [31:0]    snap_ctx,
  output logic [31:0]    snap_vm
);
  localparam int HIW = PCW - 32;
  localparam int GAP = 28 - VMW;

  logic [31:0] vm_word;
  assign vm_word = {ns_in, el2_in, el3_in, wide_in, {GAP{1'b0}}, vmid_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_hi <= '0;
    else if (capture) snap_hi <= 32'(pc_in[PCW-1:32]);
  end

  generate
    if (MODE >= 2) begin : g_ctx
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_ctx <= '0;
        else if (capture) snap_ctx <= ctx_in;
      end
    end else begin : g_no_ctx
      assign snap_ctx = '0;
    end

    if (MODE >= 3) begin : g_vm
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_vm <= '0;
        else if (capture) snap_vm <= vm_word;
      end
    end else begin : g_no_vm
      assign snap_vm = '0;
    end
  endgenerate

  logic unused_lo;
  assign unused_lo = ^{pc_in[31:0], HIW[0]};
endmodule

// File: rtl/pcs_pwr_lock.sv
module pcs_pwr_lock
  import pcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_oslock,
  input  logic        wr_pwrctl,
  input  logic [31:0] wdata,
  output logic        os_locked,
  output logic        ctl_pwrup,
  output logic        ctl_nopd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         os_locked <= 1'b1;
    else if (wr_oslock) os_locked <= |wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_pwrup <= 1'b0;
      ctl_nopd  <= 1'b0;
    end else if (wr_pwrctl) begin
      ctl_pwrup <= wdata[CTL_PWRUP_BIT];
      ctl_nopd  <= wdata[CTL_NOPD_BIT];
    end
  end
endmodule

// File: rtl/pcs_dbg_regs.sv
module pcs_dbg_regs
  import pcs_pkg::*;
#(
  parameter int AW      = 12,
  parameter int PCW     = 64,
  parameter int VMW     = 8,
  parameter int MODE    = 3,
  parameter int PCS_OFS = 1
) (
  input  logic           pclk,
  input  logic           presetn,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [31:0]    pwdata,
  output logic [31:0]    prdata,
  output logic           pready,
  output logic           pslverr,
  input  logic [PCW-1:0] core_pc,
  input  logic [31:0]    core_ctxid,
  input  logic [VMW-1:0] core_vmid,
  input  logic           core_ns,
  input  logic           core_el2,
  input  logic           core_el3,
  input  logic           core_wide,
  input  logic           core_halted,
  input  logic           prof_prohibit,
  input  logic           core_pwr_up,
  input  logic           core_dlock,
  output logic           req_pwrup,
  output logic           req_nopd
);
  localparam logic [3:0] MODE_CODE = 4'(MODE);
  localparam logic [3:0] OFS_CODE  = 4'(PCS_OFS);

  reg_sel_e    sel;
  logic        is_sample;
  logic        access, rd_en, wr_en;
  logic        blocked, no_sample;
  logic        capture;
  logic        os_locked;
  logic [31:0] snap_hi, snap_ctx, snap_vm;
  logic [31:0] status_word, ctl_word;

  pcs_addr_dec #(.AW(AW)) u_dec (
    .paddr     (paddr),
    .sel       (sel),
    .is_sample (is_sample)
  );

  assign access    = psel & penable;
  assign rd_en     = access & ~pwrite;
  assign wr_en     = access & pwrite;
  assign blocked   = ~core_pwr_up | core_dlock;
  assign no_sample = core_halted | prof_prohibit;
  assign capture   = rd_en & (sel == SEL_PCLO) & ~blocked & ~no_sample & ~os_locked;

  pcs_sample_bank #(.PCW(PCW), .VMW(VMW), .MODE(MODE)) u_bank (
    .clk      (pclk),
    .rst_n    (presetn),
    .capture  (capture),
    .pc_in    (core_pc),
    .ctx_in   (core_ctxid),
    .vmid_in  (core_vmid),
    .ns_in    (core_ns),
    .el2_in   (core_el2),
    .el3_in   (core_el3),
    .wide_in  (core_wide),
    .snap_hi  (snap_hi),
    .snap_ctx (snap_ctx),
    .snap_vm  (snap_vm)
  );

  pcs_pwr_lock u_pwr (
    .clk       (pclk),
    .rst_n     (presetn),
    .wr_oslock (wr_en & (sel == SEL_OSLOCK)),
    .wr_pwrctl (wr_en & (sel == SEL_PWRCTL)),
    .wdata     (pwdata),
    .os_locked (os_locked),
    .ctl_pwrup (req_pwrup),
    .ctl_nopd  (req_nopd)
  );

  always_comb begin
    status_word = '0;
    status_word[ST_PWR_BIT]  = core_pwr_up;
    status_word[ST_OSLK_BIT] = os_locked;
    status_word[ST_DLK_BIT]  = core_dlock;
    ctl_word = '0;
    ctl_word[CTL_PWRUP_BIT]  = req_pwrup;
    ctl_word[CTL_NOPD_BIT]   = req_nopd;
  end

  always_comb begin
    prdata = '0;
    if (rd_en && !(is_sample && blocked)) begin
      case (sel)
        SEL_PCLO:    prdata = no_sample ? SAMPLE_BLOCKED : core_pc[31:0];
        SEL_CTX:     prdata = snap_ctx;
        SEL_VMID:    prdata = snap_vm;
        SEL_PCHI:    prdata = snap_hi;
        SEL_PWRCTL:  prdata = ctl_word;
        SEL_PWRSTAT: prdata = status_word;
        SEL_DEVID1:  prdata = {28'd0, OFS_CODE};
        SEL_DEVID:   prdata = {28'd0, MODE_CODE};
        default:     prdata = '0;
      endcase
    end
  end

  assign pslverr = access & is_sample & blocked;
  assign pready  = 1'b1;
endmodule

// File: rtl/pcs_dbg_regs_chk.sv
module pcs_dbg_regs_chk #(
  parameter int AW  = 12,
  parameter int PCW = 64
) (
  input logic           pclk,
  input logic           presetn,
  input logic           psel,
  input logic           penable,
  input logic           pwrite,
  input logic [AW-1:0]  paddr,
  input logic [31:0]    pwdata,
  input logic [31:0]    prdata,
  input logic           pslverr,
  input logic [PCW-1:0] core_pc,
  input logic           core_halted,
  input logic           prof_prohibit,
  input logic           core_pwr_up,
  input logic           core_dlock,
  input logic           req_pwrup,
  input logic           req_nopd,
  input logic           os_locked,
  input logic [31:0]    snap_hi,
  input logic [31:0]    snap_ctx
);
  logic acc, rd, wr, blk, at_lo, at_smp, at_ctl;
  assign acc    = psel && penable;
  assign rd     = acc && !pwrite;
  assign wr     = acc && pwrite;
  assign blk    = !core_pwr_up || core_dlock;
  assign at_lo  = (paddr == AW'(12'h0A0));
  assign at_smp = (paddr == AW'(12'h0A0)) || (paddr == AW'(12'h0A4)) ||
                  (paddr == AW'(12'h0A8)) || (paddr == AW'(12'h0AC));
  assign at_ctl = (paddr == AW'(12'h300)) || (paddr == AW'(12'h310)) ||
                  (paddr == AW'(12'h314)) || (paddr == AW'(12'hFC4)) ||
                  (paddr == AW'(12'hFC8));

  AST_CAPTURE_HI: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && at_lo && !blk && !core_halted && !prof_prohibit && !os_locked)
      |=> snap_hi == 32'($past(core_pc[PCW-1:32]))); // R2

  AST_PROHIBIT_ONES: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && at_lo && !blk && (core_halted || prof_prohibit))
      |-> prdata == 32'hFFFF_FFFF); // R3

  AST_LOCK_NO_CAPTURE: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && at_lo && os_locked) |=> $stable(snap_hi) && $stable(snap_ctx)); // R5

  AST_BLOCKED_ERR: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && at_smp && blk) |-> pslverr && prdata == 32'd0); // R6

  AST_CTRL_NO_ERR: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && at_ctl) |-> !pslverr); // R7

  AST_STATUS_BITS: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && paddr == AW'(12'h314))
      |-> prdata[0] == core_pwr_up && prdata[6] == core_dlock && prdata[5] == os_locked); // R8

  AST_REQ_FOLLOW: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && paddr == AW'(12'h310))
      |=> req_pwrup == $past(pwdata[3]) && req_nopd == $past(pwdata[0])); // R9
endmodule

bind pcs_dbg_regs pcs_dbg_regs_chk #(.AW(AW), .PCW(PCW)) u_chk (
  .pclk          (pclk),
  .presetn       (presetn),
  .psel          (psel),
  .penable       (penable),
  .pwrite        (pwrite),
  .paddr         (paddr),
  .pwdata        (pwdata),
  .prdata        (prdata),
  .pslverr       (pslverr),
  .core_pc       (core_pc),
  .core_halted   (core_halted),
  .prof_prohibit (prof_prohibit),
  .core_pwr_up   (core_pwr_up),
  .core_dlock    (core_dlock),
  .req_pwrup     (req_pwrup),
  .req_nopd      (req_nopd),
  .os_locked     (os_locked),
  .snap_hi       (snap_hi),
  .snap_ctx      (snap_ctx)
);

// File: tb/pcs_dbg_regs_test.sv
`timescale 1ns/1ps
module pcs_dbg_regs_test;
  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h300, 32'h0,          32'h0,          1'b0}, // R5 unlock
    '{1'b0, 12'h314, 32'h0,          32'h0000_0001,  1'b0}, // R8
    '{1'b0, 12'h0A0, 32'h0,          32'h9ABC_DEF0,  1'b0}, // R2
    '{1'b0, 12'h0AC, 32'h0,          32'h1234_5678,  1'b0}, // R2
    '{1'b0, 12'h0A4, 32'h0,          32'hCAFE_0001,  1'b0}, // R2
    '{1'b0, 12'h0A8, 32'h0,          32'hB000_005A,  1'b0}, // R4
    '{1'b1, 12'h310, 32'hFFFF_FFFF,  32'h0,          1'b0}, // R9
    '{1'b0, 12'h310, 32'h0,          32'h0000_0009,  1'b0}, // R9
    '{1'b0, 12'hFC8, 32'h0,          32'h0000_0003,  1'b0}, // R10
    '{1'b0, 12'hFC4, 32'h0,          32'h0000_0001,  1'b0}, // R10
    '{1'b0, 12'h200, 32'h0,          32'h0,          1'b0}, // R11
    '{1'b1, 12'h0AC, 32'h0000_FFFF,  32'h0,          1'b0}, // R11
    '{1'b0, 12'h0AC, 32'h0,          32'h1234_5678,  1'b0}  // R11
  };

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [63:0] core_pc = 64'h1234_5678_9ABC_DEF0;
  logic [31:0] core_ctxid = 32'hCAFE_0001;
  logic [7:0]  core_vmid = 8'h5A;
  logic        core_ns = 1'b1, core_el2 = 1'b0, core_el3 = 1'b1, core_wide = 1'b1;
  logic        core_halted = 1'b0, prof_prohibit = 1'b0;
  logic        core_pwr_up = 1'b1, core_dlock = 1'b0;

  logic [31:0] prdata, prdata_m1;
  logic        pready, pslverr, req_pwrup, req_nopd;
  logic        pready_m1, pslverr_m1, req_pwrup_m1, req_nopd_m1;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] rd, rd2;
  logic        er;
  bit          done = 1'b0;

  always #2.5 pclk = ~pclk;

  pcs_dbg_regs uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .core_pc(core_pc),
    .core_ctxid(core_ctxid), .core_vmid(core_vmid), .core_ns(core_ns),
    .core_el2(core_el2), .core_el3(core_el3), .core_wide(core_wide),
    .core_halted(core_halted), .prof_prohibit(prof_prohibit),
    .core_pwr_up(core_pwr_up), .core_dlock(core_dlock),
    .req_pwrup(req_pwrup), .req_nopd(req_nopd)
  );

  pcs_dbg_regs #(.MODE(1)) uut_m1 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_m1),
    .pready(pready_m1), .pslverr(pslverr_m1), .core_pc(core_pc),
    .core_ctxid(core_ctxid), .core_vmid(core_vmid), .core_ns(core_ns),
    .core_el2(core_el2), .core_el3(core_el3), .core_wide(core_wide),
    .core_halted(core_halted), .prof_prohibit(prof_prohibit),
    .core_pwr_up(core_pwr_up), .core_dlock(core_dlock),
    .req_pwrup(req_pwrup_m1), .req_nopd(req_nopd_m1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    rd = prdata; er = pslverr; rd2 = prdata_m1;
    @(posedge pclk);
    #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge pclk);
    #1 presetn = 1'b1;

    // R1 reset state
    #1;
    check("R1 req_pwrup", {31'd0, req_pwrup}, 32'd0);
    check("R1 req_nopd", {31'd0, req_nopd}, 32'd0);
    check("R1 pready", {31'd0, pready}, 32'd1);
    apb(1'b0, 12'h314, 0); check("R1 status oslock", rd, 32'h0000_0021);
    apb(1'b0, 12'h0AC, 0); check("R1 snapshot zero", rd, 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      apb(VECS[i].wr, VECS[i].addr, VECS[i].wd);
      if (!VECS[i].wr) check($sformatf("vector %0d data", i), rd, VECS[i].exp);
      check($sformatf("vector %0d err", i), {31'd0, er}, {31'd0, VECS[i].err});
    end
    check("R9 req_pwrup", {31'd0, req_pwrup}, 32'd1);
    check("R9 req_nopd", {31'd0, req_nopd}, 32'd1);

    // R2 coherency: live inputs change, snapshots hold
    core_pc = 64'hAAAA_0001_BBBB_0004; core_ctxid = 32'h0000_7777; core_vmid = 8'h11;
    core_ns = 1'b0; core_el3 = 1'b0; core_el2 = 1'b1; core_wide = 1'b0;
    apb(1'b0, 12'h0AC, 0); check("R2 hi held", rd, 32'h1234_5678);
    apb(1'b0, 12'h0A4, 0); check("R2 ctx held", rd, 32'hCAFE_0001);

    // R5 OS lock blocks capture
    apb(1'b1, 12'h300, 32'h0000_0100);
    apb(1'b0, 12'h314, 0); check("R5 lock set", rd, 32'h0000_0021);
    apb(1'b0, 12'h0A0, 0); check("R5 live low", rd, 32'hBBBB_0004);
    apb(1'b0, 12'h0AC, 0); check("R5 no capture", rd, 32'h1234_5678);
    apb(1'b1, 12'h300, 32'h0);

    // R3 prohibited and halted
    prof_prohibit = 1'b1;
    apb(1'b0, 12'h0A0, 0); check("R3 prohibit ones", rd, 32'hFFFF_FFFF);
    apb(1'b0, 12'h0AC, 0); check("R3 no capture", rd, 32'h1234_5678);
    prof_prohibit = 1'b0; core_halted = 1'b1;
    apb(1'b0, 12'h0A0, 0); check("R3 halted ones", rd, 32'hFFFF_FFFF);
    core_halted = 1'b0;

    // R2 and R4 fresh capture with new state
    apb(1'b0, 12'h0A0, 0); check("R2 live low", rd, 32'hBBBB_0004);
    apb(1'b0, 12'h0AC, 0); check("R2 new hi", rd, 32'hAAAA_0001);
    apb(1'b0, 12'h0A8, 0); check("R4 new vmid word", rd, 32'h4000_0011);

    // R6 and R7 powered off
    core_pwr_up = 1'b0;
    apb(1'b0, 12'h0A0, 0);
    check("R6 off data", rd, 32'd0); check("R6 off err", {31'd0, er}, 32'd1);
    apb(1'b0, 12'h0A8, 0);
    check("R6 off vmid err", {31'd0, er}, 32'd1);
    apb(1'b0, 12'h314, 0);
    check("R7 status off", rd, 32'd0); check("R7 status no err", {31'd0, er}, 32'd0);
    apb(1'b1, 12'h310, 32'h0000_0008);
    check("R7 ctl write no err", {31'd0, er}, 32'd0);
    check("R9 pwrup only", {30'd0, req_pwrup, req_nopd}, 32'd2);
    apb(1'b0, 12'hFC8, 0); check("R7 devid no err", {31'd0, er}, 32'd0);

    // R6 double lock
    core_pwr_up = 1'b1; core_dlock = 1'b1;
    core_pc = 64'h5555_0000_0000_0000;
    apb(1'b0, 12'h0A0, 0); check("R6 dlock err", {31'd0, er}, 32'd1);
    apb(1'b0, 12'h314, 0); check("R8 dlock status", rd, 32'h0000_0041);
    core_dlock = 1'b0;
    apb(1'b0, 12'h0AC, 0); check("R6 no capture", rd, 32'hAAAA_0001);

    // R11 misaligned address
    apb(1'b0, 12'h311, 0); check("R11 misaligned", rd, 32'd0);

    // R12 PC-only instance (its OS lock was cleared by the shared writes)
    apb(1'b0, 12'h0A0, 0);
    apb(1'b0, 12'h0A4, 0); check("R12 ctx absent", rd2, 32'd0);
    apb(1'b0, 12'h0A8, 0); check("R12 vmid absent", rd2, 32'd0);
    apb(1'b0, 12'h0AC, 0); check("R12 hi present", rd2, 32'h5555_0000);
    apb(1'b0, 12'hFC8, 0); check("R12 mode id", rd2, 32'd1);

    finish_run();
  end
endmodule